// File: doc/BRIEF.md
# Paired-Fetch Program Counter

This block produces the instruction-fetch addresses for a front end that reads two sequential instruction words per cycle. It holds a single program counter and presents two word addresses to the instruction memory: the counter itself for the lower slot, and the counter plus one for the upper slot. While fetch runs freely, the counter moves forward by two words per cycle. When the execute stage resolves a branch as taken, the counter is loaded from the supplied target. While the front end is stalled, the counter keeps its value.

Each slot has a fetch-valid flag that marks the pair on the address outputs as worth fetching. A redirect reported by the execute stage makes the pair currently being presented a wrong-path pair. In that cycle both flags drop, so the upper word, which pairs with the control transfer, is discarded along with the lower one. Addresses are word addresses of a parameterised width, 16 bits by default, and wrap around modulo two to that width.

Top module: `pair_fetch_pc`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `fetchAddr0` is 0 and both `fetchValid0` and `fetchValid1` are 0.
- R2: The first clock edge after reset release does not advance the counter. After that edge the pair 0/1 is presented with both valid flags at 1.
- R3: Once out of reset, an edge with `stall` low and `brTaken` low advances `fetchAddr0` by exactly 2.
- R4: `fetchAddr1` always equals `fetchAddr0 + 1` modulo 2^16.
- R5: An edge with `stall` high and `brTaken` low leaves `fetchAddr0` unchanged. The valid flags stay at 1.
- R6: An edge with `brTaken` high loads `fetchAddr0` with `brTarget`, whether `stall` is high or low.
- R7: In any cycle where `brTaken` is high, `fetchValid0` and `fetchValid1` are both 0.
- R8: The counter wraps modulo 2^16, so 0xFFFE advances to 0x0000, and a counter at 0xFFFF gives `fetchAddr1` = 0x0000.
- R9: A target of either parity is accepted as is. An odd target T gives the pair T and T+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| stall | input | 1 | Front-end stall; holds the counter |
| brTaken | input | 1 | Execute stage reports a taken control transfer |
| brTarget | input | 16 | Word address to redirect fetch to |
| fetchAddr0 | output | 16 | Lower-slot fetch word address (the counter) |
| fetchAddr1 | output | 16 | Upper-slot fetch word address (counter + 1) |
| fetchValid0 | output | 1 | Lower-slot fetch is on the correct path |
| fetchValid1 | output | 1 | Upper-slot fetch is on the correct path |

## Verification
The assertions assume the following about the inputs:
- `stall`, `brTaken` and `brTarget` are synchronous and stay steady around each rising edge.
- `brTarget` matters only in a cycle where `brTaken` is high.
- Reset is held low across at least one edge.

The bench changes every input a short delay after a rising edge and samples outputs before the next one. It holds reset for several edges and then drops it once more in the middle of a run. Redirects are tried with `stall` both low and high, to odd targets, and to targets next to the top of the address space.

// File: rtl/pair_fetch_pkg.sv
package pair_fetch_pkg;

  // Strobes issued by the control half to the datapath half each cycle.
  typedef struct packed {
    logic loadTarget;  // take the redirect target
    logic advance;     // step the counter by one fetch pair
  } pcStrobes_t;

endpackage

// File: rtl/pair_fetch_ctrl.sv
module pair_fetch_ctrl
  import pair_fetch_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stall,
  input  logic             brTaken,
  output pcStrobes_t       strobes,
  output logic [LANES-1:0] fetchValid
);

  // Set one edge after reset release; until then the counter is held.
  logic armed;

  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  always_comb begin
    strobes.loadTarget = brTaken;
    strobes.advance    = armed && !stall && !brTaken;
  end

  // A redirect squashes every lane of the pair presented in the same cycle.
  for (genvar lane = 0; lane < LANES; lane++) begin : g_valid
    assign fetchValid[lane] = armed && !brTaken;
  end

  // R7: the presented pair is never valid in a redirect cycle.
  a_r7_squash_pair: assert property (@(posedge clk) disable iff (!rstN)
    brTaken |-> (fetchValid == '0));

  // R1: a cycle spent in reset is followed by a cycle with no valid lanes.
  a_r1_reset_clears: assert property (@(posedge clk)
    !rstN |=> (fetchValid == '0));

  // R5: a stall without a redirect keeps the lanes valid once they are armed.
  a_r5_stall_keeps_valid: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !brTaken && fetchValid[0]) |=> (brTaken || fetchValid[0]));

endmodule

// File: rtl/pair_fetch_dp.sv
module pair_fetch_dp
  import pair_fetch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LANES  = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  pcStrobes_t                   strobes,
  input  logic [ADDR_W-1:0]            target,
  output logic [LANES-1:0][ADDR_W-1:0] fetchAddr
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(LANES);

  logic [ADDR_W-1:0] pcReg;
  logic [ADDR_W-1:0] pcNext;

  // Redirect first, then advance, otherwise hold.
  always_comb begin
    if (strobes.loadTarget)   pcNext = target;
    else if (strobes.advance) pcNext = pcReg + STEP;
    else                      pcNext = pcReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pcReg <= '0;
    else       pcReg <= pcNext;
  end

  // One sequential address per lane; the addition wraps at the address width.
  for (genvar lane = 0; lane < LANES; lane++) begin : g_addr
    assign fetchAddr[lane] = pcReg + ADDR_W'(lane);
  end

  // R3: an advance strobe moves the counter by one pair.
  a_r3_advance: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && !strobes.loadTarget) |=> (pcReg == $past(pcReg) + STEP));

  // R6: a load strobe takes the target on the next edge.
  a_r6_redirect: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadTarget |=> (pcReg == $past(target)));

  // R5: without any strobe the counter is frozen.
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadTarget && !strobes.advance) |=> $stable(pcReg));

endmodule

// File: rtl/pair_fetch_pc.sv
module pair_fetch_pc
  import pair_fetch_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stall,
  input  logic              brTaken,
  input  logic [ADDR_W-1:0] brTarget,
  output logic [ADDR_W-1:0] fetchAddr0,
  output logic [ADDR_W-1:0] fetchAddr1,
  output logic              fetchValid0,
  output logic              fetchValid1
);

  localparam int LANES = 2;

  pcStrobes_t                   strobes;
  logic [LANES-1:0]             laneValid;
  logic [LANES-1:0][ADDR_W-1:0] laneAddr;

  pair_fetch_ctrl #(.LANES(LANES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .stall      (stall),
    .brTaken    (brTaken),
    .strobes    (strobes),
    .fetchValid (laneValid)
  );

  pair_fetch_dp #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .target    (brTarget),
    .fetchAddr (laneAddr)
  );

  assign fetchAddr0  = laneAddr[0];
  assign fetchAddr1  = laneAddr[1];
  assign fetchValid0 = laneValid[0];
  assign fetchValid1 = laneValid[1];

  // R4: the upper lane always trails the lower by one word.
  a_r4_pair_adjacent: assert property (@(posedge clk) disable iff (!rstN)
    fetchAddr1 == ADDR_W'(fetchAddr0 + ADDR_W'(1)));

endmodule

// File: tb/pair_fetch_pc_tb.sv
module pair_fetch_pc_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        stall;
  logic        brTaken;
  logic [15:0] brTarget;
  logic [15:0] fetchAddr0, fetchAddr1;
  logic        fetchValid0, fetchValid1;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pair_fetch_pc u_dut (
    .clk(clk), .rstN(rstN), .stall(stall), .brTaken(brTaken), .brTarget(brTarget),
    .fetchAddr0(fetchAddr0), .fetchAddr1(fetchAddr1),
    .fetchValid0(fetchValid0), .fetchValid1(fetchValid1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Advance to just after the next rising edge; inputs change here.
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic checkPair(input string req, input logic [15:0] pc, input logic v);
    check({req, " addr0"}, 32'(fetchAddr0), 32'(pc));
    check({req, " addr1 (R4)"}, 32'(fetchAddr1), 32'(16'(pc + 16'd1)));
    check({req, " valid0"}, 32'(fetchValid0), 32'(v));
    check({req, " valid1"}, 32'(fetchValid1), 32'(v));
  endtask

  task automatic testReset();
    rstN = 1'b0; stall = 1'b0; brTaken = 1'b0; brTarget = '0;
    repeat (3) tick();
    checkPair("R1 in reset", 16'h0000, 1'b0);
    rstN = 1'b1;
    #1 checkPair("R1 first cycle out", 16'h0000, 1'b0);
    tick();
    checkPair("R2 first pair", 16'h0000, 1'b1);
  endtask

  task automatic testAdvance(input logic [15:0] startPc, input int n);
    logic [15:0] pc = startPc;
    for (int i = 0; i < n; i++) begin
      tick();
      pc = pc + 16'd2;
      checkPair("R3 advance", pc, 1'b1);
    end
  endtask

  task automatic testStall(input logic [15:0] pc);
    stall = 1'b1;
    tick();
    checkPair("R5 stall edge 1", pc, 1'b1);
    tick();
    checkPair("R5 stall edge 2", pc, 1'b1);
    stall = 1'b0;
  endtask

  task automatic redirect(input string req, input logic [15:0] tgt, input logic st);
    stall = st; brTaken = 1'b1; brTarget = tgt;
    #1;
    check({req, " R7 valid0 squashed"}, 32'(fetchValid0), 32'd0);
    check({req, " R7 valid1 squashed"}, 32'(fetchValid1), 32'd0);
    tick();
    brTaken = 1'b0; brTarget = 16'hDEAD;
    #1 checkPair({req, " R6 target"}, tgt, 1'b1);
  endtask

  task automatic testRedirectUnderStall();
    redirect("R6 stall+redirect R9 odd", 16'h0457, 1'b1);
    tick();  // stall still high: hold at target
    checkPair("R5 hold after redirect", 16'h0457, 1'b1);
    stall = 1'b0;
    tick();
    checkPair("R9 odd advance", 16'h0459, 1'b1);
  endtask

  task automatic testWrap();
    redirect("R8 to FFFE", 16'hFFFE, 1'b0);
    tick();
    checkPair("R8 wrap to 0", 16'h0000, 1'b1);
    redirect("R8 to FFFF", 16'hFFFF, 1'b0);
    check("R8 addr1 wraps", 32'(fetchAddr1), 32'h0000);
    tick();
    checkPair("R8 odd wrap", 16'h0001, 1'b1);
  endtask

  task automatic testMidReset();
    rstN = 1'b0;
    tick();
    checkPair("R1 mid-run reset", 16'h0000, 1'b0);
    rstN = 1'b1;
    tick();
    checkPair("R2 restart", 16'h0000, 1'b1);
    testAdvance(16'h0000, 2);
  endtask

  initial begin
    testReset();
    testAdvance(16'h0000, 3);       // now at 6
    testStall(16'h0006);
    testAdvance(16'h0006, 1);       // now at 8
    redirect("R6 plain", 16'h1234, 1'b0);
    testAdvance(16'h1234, 2);
    testRedirectUnderStall();
    testWrap();
    testMidReset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule